// File: doc/BRIEF.md
# Time-Multiplexed Signal Link

This block moves a set of single-bit logical signals from a sending partition to a receiving partition over far fewer physical wires than signals. Every emulation cycle is cut into a fixed number of fast microcycles. The first microcycle is a compute slot: the sender freezes its logical inputs into a snapshot. Each later microcycle is a communication slot, in which a fixed set of signals owns the wires. The receiver copies each arriving bit into that signal's own holding register, and the bit stays there until the same slot of the next emulation cycle.

Some signals have no direct wire and go through an intermediate partition. They spend one slot on the first hop into a relay register and a later slot on the second hop to the receiver. The schedule is fixed when the design is elaborated, from the parameters. Each of the three partitions runs its own one-hot microcycle ring. A single start pulse aligns all three rings, and a done strobe marks the last microcycle so that the user design's state can advance once per emulation cycle.

Top module: `tdm_link_top`

## Requirements
- R1: While reset is high, and after reset until the first start pulse, `sig_out` is all zero, `cycle_done` is low and no slot is active.
- R2: A start pulse makes the next clock cycle microcycle 0, even if it arrives in the middle of an emulation cycle. The sender, relay and receiver rings always hold the same state, so the first `cycle_done` comes M-1 cycles after the cycle that follows the start edge.
- R3: Once started, exactly one microcycle is active, and the active microcycle moves up by one every clock. An emulation cycle has M = 1 + max(ceil(N_DIR/N_PIN), N_REL+1) microcycles (M = 4 by default), so `cycle_done` pulses every M clocks.
- R4: `sig_in` is sampled only at the end of microcycle 0. Values that `sig_in` takes in any other microcycle do not reach the outputs in that emulation cycle, and after the last microcycle `sig_out` equals the snapshot taken in microcycle 0.
- R5: Direct signal i (0 <= i < N_DIR) uses direct wire i mod N_PIN in microcycle 1 + i/N_PIN (integer division). `sig_out[i]` takes the snapshot value at the end of that microcycle.
- R6: Relayed signal N_DIR+j (0 <= j < N_REL) crosses the first hop in microcycle 1+j into the relay register and the second hop in microcycle 2+j. `sig_out[N_DIR+j]` takes the snapshot value at the end of microcycle 2+j.
- R7: A bit of `sig_out` changes only at the end of its own arrival microcycle and holds its value in every other microcycle.
- R8: `cycle_done` is high during microcycle M-1 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | microcycle clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | aligns all microcycle rings to microcycle 0 |
| sig_in | input | N_DIR+N_REL | logical signals in the sending partition |
| sig_out | output | N_DIR+N_REL | held copies in the receiving partition |
| cycle_done | output | 1 | high in the last microcycle of each emulation cycle |

## Verification
If one ring gets out of step, or the one-hot state holds a wrong bit, the fault shows at the ports within one emulation cycle. `cycle_done` then comes in the wrong clock, or a bit of `sig_out` is loaded from the wrong wire or in the wrong microcycle. A relay register that goes stale corrupts only its relayed output, and this shows at the end of microcycle 2+j. A snapshot taken at the wrong time makes `sig_out` differ from what `sig_in` held in microcycle 0, and this shows by the end of the same emulation cycle. The bench drives random inputs on every clock and compares every output on every clock, so each of these faults is reported in the cycle in which it first reaches a port.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;

  // Microcycles per emulation cycle: one compute slot plus enough
  // communication slots for the direct wires and for both relay hops.
  function automatic int micro_count(input int nd, input int nr, input int np);
    int dir_slots;
    int rel_slots;
    dir_slots = (nd + np - 1) / np;
    rel_slots = nr + 1;
    return 1 + ((dir_slots > rel_slots) ? dir_slots : rel_slots);
  endfunction

  // Slot in which direct signal i crosses.
  function automatic int dir_slot(input int i, input int np);
    return 1 + i / np;
  endfunction

  // Slots of the two hops of relayed signal j.
  function automatic int hop1_slot(input int j);
    return 1 + j;
  endfunction

  function automatic int hop2_slot(input int j);
    return 2 + j;
  endfunction

endpackage

// File: rtl/tdm_seq.sv
// One-hot microcycle ring. All zero means idle; start loads slot 0.
module tdm_seq #(
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic [M-1:0] ph
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0;
    end else if (start) begin
      ph <= M'(1);
    end else begin
      ph <= {ph[M-2:0], ph[M-1]};
    end
  end

endmodule

// File: rtl/tdm_tx.sv
// Sending side: snapshot in the compute slot, scheduled drive of the wires.
module tdm_tx #(
  parameter int N_DIR = 6,
  parameter int N_REL = 2,
  parameter int N_PIN = 2,
  parameter int M     = 4,
  localparam int NSIG = N_DIR + N_REL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [M-1:0]     ph,
  input  logic [NSIG-1:0]  sig_in,
  output logic [N_PIN-1:0] dir_pin,
  output logic             ab_pin
);
  import tdm_link_pkg::*;

  logic [NSIG-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
    end else if (ph[0]) begin
      snap <= sig_in;
    end
  end

  always_comb begin
    dir_pin = '0;
    for (int i = 0; i < N_DIR; i++) begin
      dir_pin[i % N_PIN] = dir_pin[i % N_PIN] | (ph[dir_slot(i, N_PIN)] & snap[i]);
    end
  end

  always_comb begin
    ab_pin = 1'b0;
    for (int j = 0; j < N_REL; j++) begin
      ab_pin = ab_pin | (ph[hop1_slot(j)] & snap[N_DIR + j]);
    end
  end

endmodule

// File: rtl/tdm_relay.sv
// Intermediate partition: catches first-hop bits, resends them one slot later.
module tdm_relay #(
  parameter int N_REL = 2,
  parameter int M     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] ph,
  input  logic         ab_pin,
  output logic         bc_pin
);
  import tdm_link_pkg::*;

  logic [N_REL-1:0] hold;

  for (genvar j = 0; j < N_REL; j++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst) begin
        hold[j] <= 1'b0;
      end else if (ph[hop1_slot(j)]) begin
        hold[j] <= ab_pin;
      end
    end
  end

  always_comb begin
    bc_pin = 1'b0;
    for (int j = 0; j < N_REL; j++) begin
      bc_pin = bc_pin | (ph[hop2_slot(j)] & hold[j]);
    end
  end

endmodule

// File: rtl/tdm_rx.sv
// Receiving side: one holding register per logical signal.
module tdm_rx #(
  parameter int N_DIR = 6,
  parameter int N_REL = 2,
  parameter int N_PIN = 2,
  parameter int M     = 4,
  localparam int NSIG = N_DIR + N_REL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [M-1:0]     ph,
  input  logic [N_PIN-1:0] dir_pin,
  input  logic             bc_pin,
  output logic [NSIG-1:0]  sig_out
);
  import tdm_link_pkg::*;

  for (genvar i = 0; i < N_DIR; i++) begin : g_dir
    always_ff @(posedge clk) begin
      if (rst) begin
        sig_out[i] <= 1'b0;
      end else if (ph[dir_slot(i, N_PIN)]) begin
        sig_out[i] <= dir_pin[i % N_PIN];
      end
    end
  end

  for (genvar j = 0; j < N_REL; j++) begin : g_rel
    always_ff @(posedge clk) begin
      if (rst) begin
        sig_out[N_DIR + j] <= 1'b0;
      end else if (ph[hop2_slot(j)]) begin
        sig_out[N_DIR + j] <= bc_pin;
      end
    end
  end

endmodule

// File: rtl/tdm_link_top.sv
module tdm_link_top #(
  parameter int N_DIR = 6,
  parameter int N_REL = 2,
  parameter int N_PIN = 2,
  localparam int NSIG = N_DIR + N_REL,
  localparam int M    = tdm_link_pkg::micro_count(N_DIR, N_REL, N_PIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NSIG-1:0] sig_in,
  output logic [NSIG-1:0] sig_out,
  output logic            cycle_done
);

  logic [M-1:0]     ph_a;
  logic [M-1:0]     ph_b;
  logic [M-1:0]     ph_c;
  logic [N_PIN-1:0] dir_pin;
  logic             ab_pin;
  logic             bc_pin;

  tdm_seq #(.M(M)) u_seq_a (.clk(clk), .rst(rst), .start(start), .ph(ph_a));
  tdm_seq #(.M(M)) u_seq_b (.clk(clk), .rst(rst), .start(start), .ph(ph_b));
  tdm_seq #(.M(M)) u_seq_c (.clk(clk), .rst(rst), .start(start), .ph(ph_c));

  tdm_tx #(.N_DIR(N_DIR), .N_REL(N_REL), .N_PIN(N_PIN), .M(M)) u_tx (
    .clk(clk), .rst(rst), .ph(ph_a), .sig_in(sig_in),
    .dir_pin(dir_pin), .ab_pin(ab_pin)
  );

  tdm_relay #(.N_REL(N_REL), .M(M)) u_relay (
    .clk(clk), .rst(rst), .ph(ph_b), .ab_pin(ab_pin), .bc_pin(bc_pin)
  );

  tdm_rx #(.N_DIR(N_DIR), .N_REL(N_REL), .N_PIN(N_PIN), .M(M)) u_rx (
    .clk(clk), .rst(rst), .ph(ph_c), .dir_pin(dir_pin), .bc_pin(bc_pin),
    .sig_out(sig_out)
  );

  assign cycle_done = ph_c[M-1];

endmodule

// File: rtl/tdm_link_chk.sv
module tdm_link_chk #(
  parameter int N_DIR = 6,
  parameter int N_REL = 2,
  parameter int N_PIN = 2,
  localparam int NSIG = N_DIR + N_REL,
  localparam int M    = tdm_link_pkg::micro_count(N_DIR, N_REL, N_PIN)
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [NSIG-1:0] sig_out,
  input logic            cycle_done,
  input logic [M-1:0]    ph_a,
  input logic [M-1:0]    ph_b,
  input logic [M-1:0]    ph_c
);
  import tdm_link_pkg::*;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) (ph_c == '0) |-> !cycle_done); // R1
  AST_LOCKSTEP: assert property (@(posedge clk) disable iff (rst) (ph_a == ph_b) && (ph_b == ph_c)); // R2
  AST_START_ALIGN: assert property (@(posedge clk) disable iff (rst) start |=> ph_c[0]); // R2
  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst) $onehot0(ph_c)); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (rst) (cycle_done && !start) |=> ph_c[0]); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) (cycle_done && !start) |=> !cycle_done); // R8

  for (genvar i = 0; i < N_DIR; i++) begin : g_dir_hold
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !ph_c[dir_slot(i, N_PIN)] |=> $stable(sig_out[i])); // R7
  end

  for (genvar j = 0; j < N_REL; j++) begin : g_rel_hold
    AST_REL_HOLD: assert property (@(posedge clk) disable iff (rst)
      !ph_c[hop2_slot(j)] |=> $stable(sig_out[N_DIR + j])); // R7
  end

endmodule

bind tdm_link_top tdm_link_chk #(.N_DIR(N_DIR), .N_REL(N_REL), .N_PIN(N_PIN)) u_chk (
  .clk(clk), .rst(rst), .start(start), .sig_out(sig_out), .cycle_done(cycle_done),
  .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c)
);

// File: tb/test_tdm_link_top.sv
`timescale 1ns/1ps
module test_tdm_link_top;
  localparam int N_DIR = 6;
  localparam int N_REL = 2;
  localparam int N_PIN = 2;
  localparam int NSIG  = N_DIR + N_REL;
  localparam int DSL   = (N_DIR + N_PIN - 1) / N_PIN;
  localparam int M     = 1 + ((DSL > N_REL + 1) ? DSL : N_REL + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NSIG-1:0] sig_in = '0;
  logic [NSIG-1:0] sig_out;
  logic cycle_done;

  always #5 clk = ~clk;

  tdm_link_top #(.N_DIR(N_DIR), .N_REL(N_REL), .N_PIN(N_PIN)) i_tdm_link_top (
    .clk(clk), .rst(rst), .start(start), .sig_in(sig_in),
    .sig_out(sig_out), .cycle_done(cycle_done)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // Behavioural reference model.
  int phase = -1;
  int lastph = -1;
  int since = 0;
  bit first_done_pending = 1'b0;
  bit seen0 = 1'b0;
  bit full = 1'b0;
  int prev_done = -1;
  logic [NSIG-1:0] expv = '0;
  logic [NSIG-1:0] snapm = '0;
  logic [N_REL-1:0] holdm = '0;
  logic [NSIG-1:0] prev_out = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      phase = -1; lastph = -1; expv = '0; snapm = '0; holdm = '0;
      seen0 = 0; full = 0; prev_done = -1; first_done_pending = 0;
    end else begin
      lastph = phase;
      if (phase >= 0) begin
        if (phase == 0) begin
          snapm = sig_in;
          seen0 = 1;
        end
        for (int i = 0; i < N_DIR; i++)
          if (phase == 1 + i / N_PIN) expv[i] = snapm[i];
        for (int j = 0; j < N_REL; j++) begin
          if (phase == 2 + j) expv[N_DIR + j] = holdm[j];
          if (phase == 1 + j) holdm[j] = snapm[N_DIR + j];
        end
        if (phase == M - 1 && seen0) begin
          full = 1;
          seen0 = 0;
        end
      end
      if (start) begin
        phase = 0; since = 0; seen0 = 0; full = 0;
        first_done_pending = 1; prev_done = -1;
      end else if (phase >= 0) begin
        phase = (phase + 1) % M;
        since++;
      end
    end
  end

  // Comparison away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      logic [NSIG-1:0] mask;
      chk(sig_out[N_DIR-1:0] == expv[N_DIR-1:0], "R5 direct outputs",
          32'(sig_out[N_DIR-1:0]), 32'(expv[N_DIR-1:0]));
      chk(sig_out[NSIG-1:N_DIR] == expv[NSIG-1:N_DIR], "R6 relayed outputs",
          32'(sig_out[NSIG-1:N_DIR]), 32'(expv[NSIG-1:N_DIR]));
      chk(cycle_done == (phase == M - 1), "R8 done strobe", 32'(cycle_done), 32'(phase == M - 1));
      if (phase < 0)
        chk(sig_out == '0 && !cycle_done, "R1 idle quiet", {sig_out, cycle_done}, '0);
      // R7: only bits whose slot just ended may move.
      mask = '0;
      for (int i = 0; i < N_DIR; i++) if (lastph == 1 + i / N_PIN) mask[i] = 1'b1;
      for (int j = 0; j < N_REL; j++) if (lastph == 2 + j) mask[N_DIR + j] = 1'b1;
      if (!rst && lastph >= 0)
        chk(((sig_out ^ prev_out) & ~mask) == '0, "R7 hold outside slot",
            32'(sig_out), 32'(prev_out));
      prev_out = sig_out;
      if (cycle_done && !rst) begin
        if (first_done_pending) begin
          chk(since == M - 1, "R2 first done after start", since, M - 1);
          first_done_pending = 0;
        end
        if (prev_done >= 0) chk(cyc - prev_done == M, "R3 done period", cyc - prev_done, M);
        prev_done = cyc;
      end
      if (full && lastph == M - 1) begin
        chk(sig_out == snapm, "R4 snapshot delivered", 32'(sig_out), 32'(snapm));
        full = 0;
      end
    end
  end

  task automatic run(input int n, input int pat);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      case (pat)
        0: sig_in = NSIG'($urandom);
        1: sig_in = '1;
        2: sig_in = '0;
        default: sig_in = (k % 2 == 0) ? {NSIG/2{2'b10}} : {NSIG/2{2'b01}};
      endcase
    end
  endtask

  task automatic pulse_start;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run(5, 0);                 // R1: idle before start
    pulse_start();             // R2
    run(40 * M, 0);            // R5 R6 R4 with random inputs
    run(3 * M, 1);
    run(3 * M, 2);
    run(4 * M, 3);
    while (phase != 2) @(negedge clk);
    pulse_start();             // R2: realign mid-cycle
    run(20 * M, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    run(4, 0);                 // R1 after reset
    pulse_start();
    run(10 * M, 0);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule